// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a 32-bit physical address. It reads two entries from page tables held in memory. A request carries the virtual address, an access kind (read, write or execute) and the physical base of the top-level directory. The walker first reads one word, the directory entry, which names the frame of a second-level table. It then reads the leaf entry in that table. The leaf entry holds the 20-bit physical frame number and the per-page flags. The answer is either the frame joined with the 12-bit page offset, or a fault code. A missing entry and a forbidden access give different fault codes.

The walker also keeps two flags in the leaf entry up to date. When an allowed access finds the referenced flag clear, or a write finds the dirty flag clear, the walker writes the updated entry back to memory before it answers. Memory is reached through one request channel with a valid/ready handshake, and one response channel. The walker handles one walk at a time.

Top module: `ptw_walker`

## Requirements
- R1: The first memory access of every walk is a read. Its address is `{ptbr[31:12], 12'h000} + 4 * va[31:22]`. The low 12 bits of ptbr are ignored.
- R2: When the directory entry is valid, the second access is a read of the leaf entry at `{dir[31:12], 12'h000} + 4 * va[21:12]`.
- R3: A walk with no fault answers with fault code 0. The physical address is `{leaf[31:12], va[11:0]}`.
- R4: A directory entry with bit 0 (valid) clear gives fault code 1 (not present) and physical address 0. No leaf read and no write are issued.
- R5: A leaf entry with bit 0 clear gives fault code 1 and physical address 0. No write-back is issued.
- R6: Each access kind needs one leaf flag. Kind 0 (read) needs bit 1. Kind 1 (write) needs bit 2. Kind 2 (execute) needs bit 3. Kind 3 is never allowed. A valid leaf without the needed flag gives fault code 2 (protection), physical address 0, and no write-back.
- R7: An allowed access whose leaf has bit 4 (referenced) clear writes the leaf back to its own address before the response. The written value has bit 4 set and all other bits unchanged.
- R8: An allowed write whose leaf has bit 5 (dirty) clear sets bit 5, and bit 4 if it is clear, in a single write-back. An allowed access that changes no flag issues no write.
- R9: `req_ready` is high only while the walker is idle. It drops in the cycle after a request is taken and returns in the cycle after the response. The response is a one-cycle pulse, and no memory request is issued while idle.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the memory request keeps its valid, address, direction and data unchanged.
- R11: ptbr is sampled only in the cycle a request is taken. A change to ptbr during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| ptbr | input | 32 | Physical base of the directory (bits 31:12 used) |
| mem_req_valid | output | 1 | Memory word access requested |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Word address of the access |
| mem_req_wdata | output | 32 | Data for a write |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Returned word |
| rsp_valid | output | 1 | Translation result present (one cycle) |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 protection |

## Verification
A single leaf write-back can carry two flag updates at once: the referenced flag set by any allowed access, and the dirty flag set by a write. The bench provokes this with a write to a page whose leaf has both flags clear. It then checks that exactly one memory write appears, carrying both bits, and that a later write to the same page issues none. Memory stalls come at random, and read latency varies between one and three cycles. The reference model in the bench predicts the exact order of memory accesses for every walk, and each handshake is compared with that prediction.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_REQ,
        S_DIR_WAIT,
        S_LEAF_REQ,
        S_LEAF_WAIT,
        S_WB,
        S_RESP
    } walk_st_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    localparam logic [1:0] FLT_NONE   = 2'd0;
    localparam logic [1:0] FLT_ABSENT = 2'd1;
    localparam logic [1:0] FLT_PROT   = 2'd2;

    // Entry flag positions
    localparam int PTE_V     = 0;
    localparam int PTE_R     = 1;
    localparam int PTE_W     = 2;
    localparam int PTE_X     = 3;
    localparam int PTE_REF   = 4;
    localparam int PTE_DIRTY = 5;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int AW          = 32,
    parameter int PAGE_BITS   = 12,
    parameter int IDX_W       = 10,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [AW-PAGE_BITS-1:0] frame,
    input  logic [IDX_W-1:0]        idx,
    output logic [AW-1:0]           addr
);
    localparam int SH = $clog2(ENTRY_BYTES);

    always_comb begin
        addr = {frame, {PAGE_BITS{1'b0}}} + (AW'(idx) << SH);
    end
endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
    import ptw_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] pte,
    input  acc_kind_e     kind,
    output logic [1:0]    fault,
    output logic          need_wb,
    output logic [DW-1:0] pte_upd
);
    logic allowed;
    logic unused_frame;

    assign unused_frame = ^pte[DW-1:PTE_DIRTY+1];

    always_comb begin
        unique case (kind)
            ACC_READ:  allowed = pte[PTE_R];
            ACC_WRITE: allowed = pte[PTE_W];
            ACC_EXEC:  allowed = pte[PTE_X];
            default:   allowed = 1'b0;
        endcase

        if (!pte[PTE_V]) begin
            fault = FLT_ABSENT;
        end else if (!allowed) begin
            fault = FLT_PROT;
        end else begin
            fault = FLT_NONE;
        end

        pte_upd = pte;
        pte_upd[PTE_REF] = 1'b1;
        if (kind == ACC_WRITE) begin
            pte_upd[PTE_DIRTY] = 1'b1;
        end
        need_wb = (fault == FLT_NONE) && (pte_upd != pte);
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int AW          = 32,
    parameter int PAGE_BITS   = 12,
    parameter int TBL_W       = 10,
    parameter int ENTRY_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [31:0]   req_vaddr,
    input  logic [1:0]    req_kind,
    input  logic [31:0]   ptbr,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [31:0]   mem_req_addr,
    output logic [31:0]   mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [31:0]   mem_rsp_rdata,
    output logic          rsp_valid,
    output logic [31:0]   rsp_paddr,
    output logic [1:0]    rsp_fault
);
    localparam int FRAME_W = AW - PAGE_BITS;
    localparam int DIR_LSB = PAGE_BITS + TBL_W;
    localparam int DIR_W   = AW - DIR_LSB;

    typedef struct packed {
        walk_st_e      st;
        logic [AW-1:0] va;
        acc_kind_e     kind;
        logic [AW-1:0] addr;
        logic          wr;
        logic [AW-1:0] wdata;
        logic [AW-1:0] paddr;
        logic [1:0]    fault;
    } walk_t;

    walk_t walk_d, walk_q;

    logic [AW-1:0] dir_addr;
    logic [AW-1:0] leaf_addr;
    logic [1:0]    leaf_fault;
    logic          leaf_need_wb;
    logic [AW-1:0] leaf_upd;
    logic          unused_bits;

    assign unused_bits = ^{ptbr[PAGE_BITS-1:0], walk_q.va[AW-1:DIR_LSB]};

    ptw_entry_addr #(
        .AW(AW), .PAGE_BITS(PAGE_BITS), .IDX_W(DIR_W), .ENTRY_BYTES(ENTRY_BYTES)
    ) u_dir_addr (
        .frame (ptbr[AW-1:PAGE_BITS]),
        .idx   (req_vaddr[AW-1:DIR_LSB]),
        .addr  (dir_addr)
    );

    ptw_entry_addr #(
        .AW(AW), .PAGE_BITS(PAGE_BITS), .IDX_W(TBL_W), .ENTRY_BYTES(ENTRY_BYTES)
    ) u_leaf_addr (
        .frame (mem_rsp_rdata[AW-1:PAGE_BITS]),
        .idx   (walk_q.va[DIR_LSB-1:PAGE_BITS]),
        .addr  (leaf_addr)
    );

    ptw_leaf_eval #(
        .DW(AW)
    ) u_leaf_eval (
        .pte     (mem_rsp_rdata),
        .kind    (walk_q.kind),
        .fault   (leaf_fault),
        .need_wb (leaf_need_wb),
        .pte_upd (leaf_upd)
    );

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    walk_d.va    = req_vaddr;
                    walk_d.kind  = acc_kind_e'(req_kind);
                    walk_d.addr  = dir_addr;
                    walk_d.wr    = 1'b0;
                    walk_d.fault = FLT_NONE;
                    walk_d.paddr = '0;
                    walk_d.st    = S_DIR_REQ;
                end
            end
            S_DIR_REQ: begin
                if (mem_req_ready) walk_d.st = S_DIR_WAIT;
            end
            S_DIR_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!mem_rsp_rdata[PTE_V]) begin
                        walk_d.fault = FLT_ABSENT;
                        walk_d.paddr = '0;
                        walk_d.st    = S_RESP;
                    end else begin
                        walk_d.addr  = leaf_addr;
                        walk_d.st    = S_LEAF_REQ;
                    end
                end
            end
            S_LEAF_REQ: begin
                if (mem_req_ready) walk_d.st = S_LEAF_WAIT;
            end
            S_LEAF_WAIT: begin
                if (mem_rsp_valid) begin
                    walk_d.fault = leaf_fault;
                    if (leaf_fault != FLT_NONE) begin
                        walk_d.paddr = '0;
                        walk_d.st    = S_RESP;
                    end else begin
                        walk_d.paddr = {mem_rsp_rdata[AW-1:PAGE_BITS],
                                        walk_q.va[PAGE_BITS-1:0]};
                        if (leaf_need_wb) begin
                            walk_d.wr    = 1'b1;
                            walk_d.wdata = leaf_upd;
                            walk_d.st    = S_WB;
                        end else begin
                            walk_d.st    = S_RESP;
                        end
                    end
                end
            end
            S_WB: begin
                if (mem_req_ready) begin
                    walk_d.wr = 1'b0;
                    walk_d.st = S_RESP;
                end
            end
            S_RESP: begin
                walk_d.st = S_IDLE;
            end
            default: begin
                walk_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q.st    <= S_IDLE;
            walk_q.va    <= '0;
            walk_q.kind  <= ACC_READ;
            walk_q.addr  <= '0;
            walk_q.wr    <= 1'b0;
            walk_q.wdata <= '0;
            walk_q.paddr <= '0;
            walk_q.fault <= FLT_NONE;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign req_ready     = (walk_q.st == S_IDLE);
    assign mem_req_valid = (walk_q.st == S_DIR_REQ) || (walk_q.st == S_LEAF_REQ)
                           || (walk_q.st == S_WB);
    assign mem_req_write = walk_q.wr;
    assign mem_req_addr  = walk_q.addr;
    assign mem_req_wdata = walk_q.wdata;
    assign rsp_valid     = (walk_q.st == S_RESP);
    assign rsp_paddr     = walk_q.paddr;
    assign rsp_fault     = walk_q.fault;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic [1:0]  req_kind,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_write,
    input logic [31:0] mem_req_addr,
    input logic [31:0] mem_req_wdata,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic [1:0]  rsp_fault
);
    logic [11:0] off_cap;
    logic [1:0]  kind_cap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_cap  <= '0;
            kind_cap <= '0;
        end else if (req_valid && req_ready) begin
            off_cap  <= req_vaddr[11:0];
            kind_cap <= req_kind;
        end
    end

    a_r9_busy_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r9_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);
    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);
    a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata)));
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_NONE) |-> (rsp_paddr[11:0] == off_cap));
    a_r4_no_addr_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == 32'h0));
    a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault != 2'd3));
    a_r7_wb_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (mem_req_wdata[PTE_V] && mem_req_wdata[PTE_REF]));
    a_r8_dirty_on_store: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write && kind_cap == 2'd1) |-> mem_req_wdata[PTE_DIRTY]);
    a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_kind      (req_kind),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault)
);

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic [31:0] ptbr = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    ptw_walker u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .ptbr(ptbr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    logic [31:0] memarr [logic [31:0]];
    logic [31:0] eq_addr [$];
    logic        eq_wr [$];
    logic [31:0] eq_data [$];
    string       eq_tag [$];
    logic [31:0] er_paddr [$];
    logic [1:0]  er_fault [$];
    string       er_tag [$];

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (memarr.exists(a)) return memarr[a];
        return 32'h0;
    endfunction

    function automatic logic [31:0] mk_leaf(input logic [19:0] fr, input bit v, r, w, x, rf, dt);
        return {fr, 6'b0, dt, rf, x, w, r, v};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic map(input logic [31:0] base, input logic [31:0] va,
                       input logic [19:0] tframe, input bit dvalid, input logic [31:0] leaf);
        memarr[{base[31:12], 12'h0} + {20'h0, va[31:22], 2'b00}] = {tframe, 11'h0, dvalid};
        memarr[{tframe, 12'h0} + {20'h0, va[21:12], 2'b00}] = leaf;
    endtask

    // Behavioural prediction of one walk, from the requirement text
    task automatic predict(input logic [31:0] base, input logic [31:0] va,
                           input logic [1:0] kind, input string tag);
        logic [31:0] da, de, la, le, nw;
        bit ok;
        da = {base[31:12], 12'h0} + 32'(va[31:22]) * 4;
        eq_addr.push_back(da); eq_wr.push_back(1'b0); eq_data.push_back('0); eq_tag.push_back("R1");
        de = rd(da);
        if (!de[0]) begin
            er_paddr.push_back('0); er_fault.push_back(2'd1); er_tag.push_back({tag, " R4"});
            return;
        end
        la = {de[31:12], 12'h0} + 32'(va[21:12]) * 4;
        eq_addr.push_back(la); eq_wr.push_back(1'b0); eq_data.push_back('0); eq_tag.push_back("R2");
        le = rd(la);
        if (!le[0]) begin
            er_paddr.push_back('0); er_fault.push_back(2'd1); er_tag.push_back({tag, " R5"});
            return;
        end
        case (kind)
            2'd0: ok = le[1];
            2'd1: ok = le[2];
            2'd2: ok = le[3];
            default: ok = 1'b0;
        endcase
        if (!ok) begin
            er_paddr.push_back('0); er_fault.push_back(2'd2); er_tag.push_back({tag, " R6"});
            return;
        end
        nw = le | 32'h10 | ((kind == 2'd1) ? 32'h20 : 32'h0);
        if (nw != le) begin
            eq_addr.push_back(la); eq_wr.push_back(1'b1); eq_data.push_back(nw);
            eq_tag.push_back((kind == 2'd1) ? "R8" : "R7");
        end
        er_paddr.push_back({le[31:12], va[11:0]}); er_fault.push_back(2'd0);
        er_tag.push_back({tag, " R3"});
    endtask

    // Monitor, memory model and cycle comparison
    bit          busy = 1'b0;
    bit          hold_prev = 1'b0;
    logic [31:0] prev_addr = '0;
    int          rd_cnt = 0;
    logic [31:0] rd_data = '0;

    always @(negedge clk) begin
        if (running) begin
            bit rdy;
            chk(req_ready == !busy, "R9", "req_ready vs model", {31'h0, req_ready}, {31'h0, !busy});
            if (req_valid && req_ready) busy = 1'b1;
            if (rsp_valid) begin
                if (er_fault.size() == 0) begin
                    chk(1'b0, "R9", "unexpected response", {30'h0, rsp_fault}, 32'h0);
                end else begin
                    string t;
                    t = er_tag.pop_front();
                    chk(rsp_paddr == er_paddr[0], t, "paddr", rsp_paddr, er_paddr[0]);
                    chk(rsp_fault == er_fault[0], t, "fault", {30'h0, rsp_fault}, {30'h0, er_fault[0]});
                    chk(eq_addr.size() == 0, t, "memory accesses left over",
                        eq_addr.size(), 32'h0);
                    void'(er_paddr.pop_front());
                    void'(er_fault.pop_front());
                end
                busy = 1'b0;
            end
            // read data return
            mem_rsp_valid = 1'b0;
            if (rd_cnt > 0) begin
                rd_cnt--;
                if (rd_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = rd_data;
                end
            end
            // R10 stability of a stalled request
            if (hold_prev) begin
                chk(mem_req_valid && mem_req_addr == prev_addr, "R10", "stalled request moved",
                    mem_req_addr, prev_addr);
            end
            rdy = ($urandom % 4) != 0;
            mem_req_ready = rdy;
            hold_prev = mem_req_valid && !rdy;
            prev_addr = mem_req_addr;
            if (mem_req_valid && rdy) begin
                if (eq_addr.size() == 0) begin
                    chk(1'b0, "R4", "unexpected memory access", mem_req_addr, 32'h0);
                end else begin
                    string t;
                    t = eq_tag.pop_front();
                    chk(mem_req_addr == eq_addr[0], t, "access address", mem_req_addr, eq_addr[0]);
                    chk(mem_req_write == eq_wr[0], t, "access direction",
                        {31'h0, mem_req_write}, {31'h0, eq_wr[0]});
                    if (eq_wr[0]) begin
                        chk(mem_req_wdata == eq_data[0], t, "write-back data", mem_req_wdata, eq_data[0]);
                    end
                    void'(eq_addr.pop_front());
                    void'(eq_wr.pop_front());
                    void'(eq_data.pop_front());
                end
                if (mem_req_write) begin
                    memarr[mem_req_addr] = mem_req_wdata;
                end else begin
                    rd_data = rd(mem_req_addr);
                    rd_cnt  = 1 + int'($urandom % 3);
                end
            end
        end
    end

    task automatic translate(input logic [31:0] va, input logic [1:0] kind,
                             input string tag, input bit wiggle_base);
        logic [31:0] base;
        @(posedge clk); #1;
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        base = ptbr;
        predict(base, va, kind, tag);
        @(posedge clk); #1;
        req_valid = 1'b0;
        req_vaddr = $urandom;
        if (wiggle_base) ptbr = 32'h0ABC_D000;
        while (er_fault.size() != 0) @(posedge clk);
        @(posedge clk); #1;
        ptbr = base;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    localparam logic [31:0] BASE = 32'h0010_0ABC; // low bits must be ignored (R1)

    initial begin
        ptbr = BASE;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "reset ready", {31'h0, req_ready}, 32'h1);
        chk(rsp_valid == 1'b0, "R9", "reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
        chk(mem_req_valid == 1'b0, "R9", "reset mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
        running = 1'b1;

        // R3: read with referenced already set, no write-back
        map(BASE, 32'h0040_1234, 20'h00200, 1'b1, mk_leaf(20'hABCDE, 1,1,0,0,1,0));
        translate(32'h0040_1234, 2'd0, "R3 read hit", 1'b0);
        // R7: read with referenced clear
        map(BASE, 32'h0080_2FFC, 20'h00201, 1'b1, mk_leaf(20'h12345, 1,1,0,0,0,0));
        translate(32'h0080_2FFC, 2'd0, "R7 ref update", 1'b0);
        // R8: write with both flags clear, then again with none to change
        map(BASE, 32'h7192_A44C, 20'h12345, 1'b1, mk_leaf(20'h14817, 1,1,1,0,0,0));
        translate(32'h7192_A44C, 2'd1, "R8 first store", 1'b0);
        translate(32'h7192_A448, 2'd1, "R8 second store", 1'b0);
        // R6: write to read-only page, execute checks, reserved kind
        map(BASE, 32'h00C0_3000, 20'h00202, 1'b1, mk_leaf(20'h00777, 1,1,0,0,1,0));
        translate(32'h00C0_3000, 2'd1, "R6 store to read-only", 1'b0);
        translate(32'h00C0_3010, 2'd2, "R6 exec no-x", 1'b0);
        map(BASE, 32'h0100_4008, 20'h00203, 1'b1, mk_leaf(20'h00888, 1,0,0,1,0,0));
        translate(32'h0100_4008, 2'd2, "R6 exec allowed", 1'b0);
        translate(32'h0100_4008, 2'd3, "R6 reserved kind", 1'b0);
        translate(32'h0100_4008, 2'd0, "R6 read no-r", 1'b0);
        // R4: directory invalid
        map(BASE, 32'hFFC0_0000, 20'h00204, 1'b0, mk_leaf(20'h00999, 1,1,1,1,1,1));
        translate(32'hFFC0_0010, 2'd0, "R4 dir absent", 1'b0);
        // R5: leaf invalid, flags otherwise set
        map(BASE, 32'h0140_5000, 20'h00205, 1'b1, mk_leaf(20'h00AAA, 0,1,1,1,0,0));
        translate(32'h0140_5000, 2'd1, "R5 leaf absent", 1'b0);
        // R11: base changes during the walk
        map(BASE, 32'h0180_6ABC, 20'h00206, 1'b1, mk_leaf(20'h00BBB, 1,1,1,0,1,1));
        translate(32'h0180_6ABC, 2'd1, "R11 base wiggle", 1'b1);

        // Mixed pages with random flags and kinds (R3 R6 R7 R8)
        for (int i = 0; i < 80; i++) begin
            logic [31:0] va;
            logic [5:0]  fl;
            va = {($urandom % 4) == 0 ? 10'h3FF : 10'(($urandom % 6) + 16),
                  10'($urandom % 8), 12'($urandom)};
            fl = 6'($urandom);
            fl[0] = (($urandom % 8) != 0);
            map(BASE, va, 20'h00300 + 20'(va[31:22]), (($urandom % 10) != 0),
                {20'($urandom), 6'b0, fl});
            translate(va, 2'($urandom), "R3 mixed", ($urandom % 2) == 1);
        end

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule